// File: doc/BRIEF.md
# Opcode-Dispatch Microsequencer

This block is the control sequencer of a multicycle processor datapath. It does not use a full next-state truth table. The current state drives a small control store. For every state, that store gives a datapath control word and a 2-bit sequencing selector. The selector chooses one of four ways to form the next state:

- return to state 0;
- step to the current state plus one;
- look up the next state in the first opcode dispatch table;
- look up the next state in the second opcode dispatch table.

Both dispatch tables are fixed constant lookups. They are indexed by the 6-bit opcode alone.

The datapath uses the control word to run fetch, decode, address calculation, memory access, ALU execution, branch and jump. The state output and the selector output are brought out so that the surrounding logic can observe the sequencing.

Top module: `op_dispatch_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the state at 0, where `ctrl_word` is 16'h9408 and `seq_sel` is 3.
- R2: When `seq_sel` is 3, the next state is the current state plus one.
- R3: When `seq_sel` is 0, the next state is 0.
- R4: When `seq_sel` is 1, the next state is taken from the first table, using these opcodes:
  - 6'b000000 (register ALU) goes to state 6;
  - 6'b000010 (jump) goes to state 9;
  - 6'b000100 (branch-equal) goes to state 8;
  - 6'b100011 (load) goes to state 2;
  - 6'b101011 (store) goes to state 2.
- R5: When `seq_sel` is 2, the next state is taken from the second table: opcode 6'b100011 goes to state 3, and 6'b101011 goes to state 5.
- R6: An opcode with no entry in the table that is selected gives next state 0.
- R7: `seq_sel` depends on the state as follows:
  - 3 in states 0, 3 and 6;
  - 1 in state 1;
  - 2 in state 2;
  - 0 in states 4, 5, 7, 8 and 9.
- R8: `ctrl_word` depends on the state only. Its values for states 0 to 9 are 9408, 0018, 0014, 3000, 0202, 2800, 0044, 0003, 40A4 and 8100 (hex). The bit fields, from bit 15 down to bit 0, are:
  - PC write;
  - conditional PC write;
  - data address select;
  - memory read;
  - memory write;
  - instruction register write;
  - write-back from memory;
  - PC source [1:0];
  - ALU operation [1:0];
  - ALU operand B [1:0];
  - ALU operand A;
  - register write;
  - destination field select.
- R9: The opcode has no effect on the next state in states whose `seq_sel` is 0 or 3.
- R10: The second table is indexed by the opcode present in state 2, not by the opcode seen in state 1. So a load opcode in decode followed by a store opcode in state 2 goes to state 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the current instruction |
| ctrl_word | output | 16 | Datapath control word for the current state |
| seq_sel | output | 2 | Next-state selector for the current state |
| state | output | 4 | Current state number |

## Verification
Two events can fall on the same clock edge: a dispatch lookup, and a reset or an opcode change. The bench asserts reset while a dispatch state is current, and it changes the opcode between decode and state 2. It also drives random opcodes in every counting and returning state. A behavioural reference holds its own tables. Each clock, it judges whether the resulting state came from the selector or from the opcode.

// File: rtl/op_dispatch_seq.sv
module op_dispatch_seq #(
  parameter int OPW = 6,
  parameter int SW  = 4,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output logic [CW-1:0]  ctrl_word,
  output logic [1:0]     seq_sel,
  output logic [SW-1:0]  state
);

  localparam logic [1:0] SEL_ZERO = 2'd0;
  localparam logic [1:0] SEL_T1   = 2'd1;
  localparam logic [1:0] SEL_T2   = 2'd2;
  localparam logic [1:0] SEL_INC  = 2'd3;

  localparam logic [OPW-1:0] OP_ALU = OPW'(0);
  localparam logic [OPW-1:0] OP_JMP = OPW'(2);
  localparam logic [OPW-1:0] OP_BEQ = OPW'(4);
  localparam logic [OPW-1:0] OP_LD  = OPW'(35);
  localparam logic [OPW-1:0] OP_ST  = OPW'(43);

  localparam logic [SW-1:0] ST_FETCH  = SW'(0);
  localparam logic [SW-1:0] ST_DECODE = SW'(1);
  localparam logic [SW-1:0] ST_MADDR  = SW'(2);
  localparam logic [SW-1:0] ST_MRD    = SW'(3);
  localparam logic [SW-1:0] ST_LDWB   = SW'(4);
  localparam logic [SW-1:0] ST_MWR    = SW'(5);
  localparam logic [SW-1:0] ST_EXEC   = SW'(6);
  localparam logic [SW-1:0] ST_ALUWB  = SW'(7);
  localparam logic [SW-1:0] ST_BRANCH = SW'(8);
  localparam logic [SW-1:0] ST_JUMP   = SW'(9);

  logic [SW-1:0] nxt;

  function automatic logic [SW-1:0] table_one(input logic [OPW-1:0] op);
    case (op)
      OP_ALU:       return ST_EXEC;
      OP_JMP:       return ST_JUMP;
      OP_BEQ:       return ST_BRANCH;
      OP_LD, OP_ST: return ST_MADDR;
      default:      return ST_FETCH;
    endcase
  endfunction

  function automatic logic [SW-1:0] table_two(input logic [OPW-1:0] op);
    case (op)
      OP_LD:   return ST_MRD;
      OP_ST:   return ST_MWR;
      default: return ST_FETCH;
    endcase
  endfunction

  always_comb begin
    ctrl_word = '0;
    seq_sel   = SEL_ZERO;
    case (state)
      ST_FETCH:  begin ctrl_word = CW'(16'h9408); seq_sel = SEL_INC; end
      ST_DECODE: begin ctrl_word = CW'(16'h0018); seq_sel = SEL_T1;  end
      ST_MADDR:  begin ctrl_word = CW'(16'h0014); seq_sel = SEL_T2;  end
      ST_MRD:    begin ctrl_word = CW'(16'h3000); seq_sel = SEL_INC; end
      ST_LDWB:   ctrl_word = CW'(16'h0202);
      ST_MWR:    ctrl_word = CW'(16'h2800);
      ST_EXEC:   begin ctrl_word = CW'(16'h0044); seq_sel = SEL_INC; end
      ST_ALUWB:  ctrl_word = CW'(16'h0003);
      ST_BRANCH: ctrl_word = CW'(16'h40A4);
      ST_JUMP:   ctrl_word = CW'(16'h8100);
      default:   ;
    endcase
  end

  always_comb begin
    case (seq_sel)
      SEL_T1:  nxt = table_one(opcode);
      SEL_T2:  nxt = table_two(opcode);
      SEL_INC: nxt = state + SW'(1);
      default: nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nxt;
  end

  assert_increment_R2: assert property (@(posedge clk) disable iff (rst)
    seq_sel == SEL_INC |=> state == SW'($past(state) + 1'b1));

  assert_return_zero_R3: assert property (@(posedge clk) disable iff (rst)
    seq_sel == SEL_ZERO |=> state == ST_FETCH);

  assert_table_one_target_R4: assert property (@(posedge clk) disable iff (rst)
    seq_sel == SEL_T1 |=> (state == ST_FETCH || state == ST_MADDR || state == ST_EXEC ||
                           state == ST_BRANCH || state == ST_JUMP));

  assert_table_two_target_R5: assert property (@(posedge clk) disable iff (rst)
    seq_sel == SEL_T2 |=> (state == ST_FETCH || state == ST_MRD || state == ST_MWR));

  assert_unknown_op_R6: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == SEL_T2 && opcode != OP_LD && opcode != OP_ST) |=> state == ST_FETCH);

  assert_mem_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_word[12] && ctrl_word[11]));

endmodule

// File: tb/op_dispatch_seq_bench.sv
module op_dispatch_seq_bench;
  localparam int CLK_P = 10;

  logic       clk = 0;
  logic       rst = 1;
  logic [5:0] opcode = '0;
  logic [15:0] ctrl_word;
  logic [1:0]  seq_sel;
  logic [3:0]  state;

  op_dispatch_seq u_op_dispatch_seq (
    .clk(clk), .rst(rst), .opcode(opcode),
    .ctrl_word(ctrl_word), .seq_sel(seq_sel), .state(state)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int ref_state = 0;
  string tag = "R1";
  bit started = 0, done = 0;
  int t1[int];
  int t2[int];
  logic [15:0] exp_ctrl[10];
  int exp_sel[10];

  initial begin
    t1[0] = 6; t1[2] = 9; t1[4] = 8; t1[35] = 2; t1[43] = 2;
    t2[35] = 3; t2[43] = 5;
    exp_ctrl = '{16'h9408, 16'h0018, 16'h0014, 16'h3000, 16'h0202,
                 16'h2800, 16'h0044, 16'h0003, 16'h40A4, 16'h8100};
    exp_sel  = '{3, 1, 2, 3, 0, 0, 3, 0, 0, 0};
  end

  always @(posedge clk) begin
    int s;
    started = 1;
    cycles++;
    if (rst) begin ref_state = 0; tag = "R1"; end
    else begin
      s = exp_sel[ref_state];
      if (s == 3) begin ref_state = ref_state + 1; tag = "R2,R9"; end
      else if (s == 0) begin ref_state = 0; tag = "R3,R9"; end
      else if (s == 1) begin
        if (t1.exists(int'(opcode))) begin ref_state = t1[int'(opcode)]; tag = "R4"; end
        else begin ref_state = 0; tag = "R6"; end
      end else begin
        if (t2.exists(int'(opcode))) begin ref_state = t2[int'(opcode)]; tag = "R5,R10"; end
        else begin ref_state = 0; tag = "R6"; end
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (int'(state) != ref_state) begin
        fails++;
        $display("FAIL %s state: actual %0d expected %0d", tag, state, ref_state);
      end
      if (ref_state < 10) begin
        checks++;
        if (ctrl_word !== exp_ctrl[ref_state]) begin
          fails++;
          $display("FAIL R8 ctrl_word: actual %h expected %h", ctrl_word, exp_ctrl[ref_state]);
        end
        checks++;
        if (int'(seq_sel) != exp_sel[ref_state]) begin
          fails++;
          $display("FAIL R7 seq_sel: actual %0d expected %0d", seq_sel, exp_sel[ref_state]);
        end
      end
    end
  end

  task automatic run_instr(input logic [5:0] op, input logic [5:0] op2);
    int guard = 0;
    do begin
      @(posedge clk); #1;
      if (ref_state == 1) opcode = op;
      else if (ref_state == 2) opcode = op2;
      else opcode = 6'($urandom);
      guard++;
    end while (ref_state != 0 && guard < 20);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    for (int k = 0; k < 4; k++) begin
      run_instr(6'd0, 6'd0);
      run_instr(6'd2, 6'd0);
      run_instr(6'd4, 6'd0);
      run_instr(6'd35, 6'd35);
      run_instr(6'd43, 6'd43);
      run_instr(6'd35, 6'd43);
      run_instr(6'd43, 6'd0);
      run_instr(6'd63, 6'd35);
      run_instr(6'd17, 6'd0);
    end
    @(posedge clk); #1 opcode = 6'd35;
    @(posedge clk); #1 rst = 1;
    @(posedge clk); #1 rst = 0;
    run_instr(6'd0, 6'd0);
    repeat (2) @(posedge clk);
    #1 finish_run();
  end

  initial begin
    wait (cycles > 5000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
    finish_run();
  end
endmodule